// File: doc/BRIEF.md
# Camera RAW Pixel Unpacker

This block turns the payload bytes of a camera serial long packet, already merged from the receive lanes into one wide word per clock, into a fixed number of pixels per clock. The bit depth of the payload is picked per packet from the six-bit data-type field presented with the first word. The block then reassembles the packed pixel groups and delivers them MSB-justified in a uniform container width. Packets whose data type is not a supported RAW code produce no pixels.

Parameters set the merged lane count (2 or 4), the per-lane deserialiser ratio (8 or 16 bits per clock), the output pixels per clock (2, 4 or 8) and the container width (14 to 16 bits). A residue byte store carries partial groups across input words, so packed groups that straddle word boundaries and input strobes with idle gaps are handled. Each output beat carries a line-start flag on the first beat of a packet and a line-end flag on the last.

The block assumes a line length that is a multiple of the pixels per clock and of the packing group, a payload length that is a whole number of input words, an average input byte rate no higher than the output can drain, and at least four idle cycles between packets.

Top module: `raw_pixel_unpacker`

## Requirements
- R1: Data type 0x2B selects 10-bit packing: each 5-byte group yields 4 pixels, byte i (i = 0..3) holds bits [9:2] of pixel i, and bits [2i+1:2i] of byte 4 hold bits [1:0] of pixel i.
- R2: Data type 0x2C selects 12-bit packing: each 3-byte group yields 2 pixels, bytes 0 and 1 hold bits [11:4] of the first and second pixel, byte 2 bits [3:0] hold the first pixel's low nibble and bits [7:4] the second's.
- R3: Data type 0x2D selects 14-bit packing: each 7-byte group yields 4 pixels, byte i (i = 0..3) holds bits [13:6] of pixel i, and bytes 4..6 form a 24-bit word (byte 4 least significant) whose bits [6i+5:6i] hold bits [5:0] of pixel i.
- R4: Each output pixel equals its raw value shifted left by (container width minus bit depth), with zeros below; pixel k of a beat occupies bits [k*W+W-1:k*W] of the output bus, and pixel 0 is the earliest in the stream. Input byte j of a word sits at bits [8j+7:8j].
- R5: A packet whose data type is none of 0x2B, 0x2C, 0x2D produces no output beats.
- R6: The format is taken afresh at each packet start, so consecutive packets of different depths are unpacked correctly without reset.
- R7: Pixel groups split across input words, and payloads delivered with idle cycles between words, are reassembled into the same pixels; the residue store never overflows.
- R8: The line-start flag is set only on the first output beat of a packet and the line-end flag only on its last; neither is set without the valid strobe.
- R9: The residue store is emptied at each packet start: bytes left over from a previous packet never enter the pixels of the next.
- R10: While reset is low and in the cycle after, the valid, line-start and line-end outputs are low.
- R11: Lane, ratio, pixels-per-clock and width combinations outside the legal set (2 pixels only with 2 lanes, 8 pixels only with 4 lanes) stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_sop | input | 1 | First payload word of a packet (with in_valid) |
| in_eop | input | 1 | Last payload word of a packet (with in_valid) |
| in_dt | input | 6 | Packet data type, sampled with in_sop |
| in_data | input | LANES*GEAR | Merged payload bytes, byte 0 least significant |
| out_valid | output | 1 | Output beat strobe |
| out_sol | output | 1 | First beat of a line |
| out_eol | output | 1 | Last beat of a line |
| out_pix | output | PPC*PIX_W | Pixels of the beat, pixel 0 in the low bits |

## Verification
Every cycle the assertions check that the residue store neither overflows nor gives up more bytes than it holds, that the line flags never appear without the valid strobe and the start flag never repeats on adjacent beats, that an unsupported data type keeps the output silent, and that reset quiets the output. The pixel values themselves, the bit layouts of the three depths, the left alignment, straddling groups under gapped input, the clearing of residue between packets and the format switch across packets can be shown only by the bench's scenarios, which compare each beat against pixels packed independently in the bench.

// File: rtl/raw_unpack_pkg.sv
// Package: shared types and helpers for the RAW pixel unpacker.
// Assumes data-type codes arrive as the six-bit field of a long packet header.
package raw_unpack_pkg;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_R10  = 2'd1,
        FMT_R12  = 2'd2,
        FMT_R14  = 2'd3
    } raw_fmt_e;

    localparam logic [5:0] DT_RAW10 = 6'h2B;
    localparam logic [5:0] DT_RAW12 = 6'h2C;
    localparam logic [5:0] DT_RAW14 = 6'h2D;

    // Map a data-type code to a packing format.
    function automatic raw_fmt_e fmt_from_dt(input logic [5:0] dt);
        case (dt)
            DT_RAW10: return FMT_R10;
            DT_RAW12: return FMT_R12;
            DT_RAW14: return FMT_R14;
            default:  return FMT_NONE;
        endcase
    endfunction

    // Bytes occupied by four pixels in the given format.
    function automatic int unit_bytes(input raw_fmt_e f);
        case (f)
            FMT_R10: return 5;
            FMT_R12: return 6;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/raw_unit_decode.sv
// Module: decodes one four-pixel unit from a seven-byte window.
// Assumes byte 0 of the window is the first byte of the unit; bytes beyond the
// unit size are ignored. Pixels come out MSB-justified in PIX_W bits.
module raw_unit_decode
    import raw_unpack_pkg::*;
#(
    parameter int PIX_W = 14
) (
    input  raw_fmt_e               fmt,
    input  logic [55:0]            win,
    output logic [4*PIX_W-1:0]     pix
);

    logic [7:0]  bt [7];
    logic [23:0] lsb14;

    // Split the window into bytes and gather the 14-bit low-bit word.
    always_comb begin
        for (int j = 0; j < 7; j++) begin
            bt[j] = win[j*8 +: 8];
        end
        lsb14 = {bt[6], bt[5], bt[4]};
    end

    // Reassemble each pixel from its MSB byte and low bits, then left-align.
    always_comb begin
        logic [PIX_W-1:0] v;
        pix = '0;
        for (int i = 0; i < 4; i++) begin
            v = '0;
            case (fmt)
                FMT_R10: v[PIX_W-1 -: 10] = {bt[i], bt[4][2*i +: 2]};
                FMT_R12: v[PIX_W-1 -: 12] = {bt[(i/2)*3 + (i%2)],
                                             bt[(i/2)*3 + 2][(i%2)*4 +: 4]};
                FMT_R14: v[PIX_W-1 -: 14] = {bt[i], lsb14[6*i +: 6]};
                default: v = '0;
            endcase
            pix[i*PIX_W +: PIX_W] = v;
        end
    end

endmodule

// File: rtl/raw_residue_buf.sv
// Module: residue byte store. Holds payload bytes oldest-first at index 0.
// Each cycle it drops pop_cnt bytes from the front, then appends a word.
// A clear empties it before the append of the same cycle.
// Assumes the caller never pops more than it holds and keeps the fill within CAP.
module raw_residue_buf #(
    parameter int IN_BYTES = 2,
    parameter int CAP      = 9,
    parameter int CNT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    push,
    input  logic [IN_BYTES*8-1:0]   push_data,
    input  logic [CNT_W-1:0]        pop_cnt,
    output logic [CAP*8-1:0]        win,
    output logic [CNT_W-1:0]        count
);

    logic [7:0]       mem_q [CAP];
    logic [7:0]       mem_d [CAP];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] base;

    // Shift out consumed bytes and place the new word behind the remainder.
    always_comb begin
        base = clear ? '0 : (cnt_q - pop_cnt);
        for (int k = 0; k < CAP; k++) begin
            if (clear) begin
                mem_d[k] = 8'h00;
            end else if (k + int'(pop_cnt) < CAP) begin
                mem_d[k] = mem_q[k + int'(pop_cnt)];
            end else begin
                mem_d[k] = 8'h00;
            end
            if (push && (k >= int'(base)) && (k < int'(base) + IN_BYTES)) begin
                mem_d[k] = push_data[(k - int'(base))*8 +: 8];
            end
        end
        cnt_d = base + (push ? CNT_W'(IN_BYTES) : '0);
    end

    // Register the byte store and its fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < CAP; k++) mem_q[k] <= 8'h00;
        end else begin
            cnt_q <= cnt_d;
            for (int k = 0; k < CAP; k++) mem_q[k] <= mem_d[k];
        end
    end

    // Present the stored bytes as a flat window.
    always_comb begin
        for (int k = 0; k < CAP; k++) win[k*8 +: 8] = mem_q[k];
    end

    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(base) + IN_BYTES <= CAP)); // R7
    AST_POP_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (pop_cnt <= cnt_q)); // R7

endmodule

// File: rtl/raw_pixel_unpacker.sv
// Module: top of the RAW pixel unpacker. Latches the packing format at each
// packet start, feeds payload bytes into the residue store, decodes PPC pixels
// per beat once enough bytes are held, and marks the first and last beats.
// Assumes: line length a multiple of PPC and of the packing group, payload a
// whole number of input words, input byte rate within the drain rate, and at
// least four idle cycles between packets.
module raw_pixel_unpacker
    import raw_unpack_pkg::*;
#(
    parameter int LANES = 2,
    parameter int GEAR  = 8,
    parameter int PPC   = 4,
    parameter int PIX_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [5:0]              in_dt,
    input  logic [LANES*GEAR-1:0]   in_data,
    output logic                    out_valid,
    output logic                    out_sol,
    output logic                    out_eol,
    output logic [PPC*PIX_W-1:0]    out_pix
);

    localparam int IN_BYTES = (LANES * GEAR) / 8;
    localparam int NG       = (PPC >= 4) ? (PPC / 4) : 1;
    localparam int DEC_PIX  = NG * 4;
    localparam int CAP      = NG * 7 + IN_BYTES;
    localparam int CNT_W    = $clog2(CAP + 1);

    // R11: reject illegal build combinations.
    if (!((LANES == 2 || LANES == 4) && (GEAR == 8 || GEAR == 16) &&
          (PPC == 2 || PPC == 4 || PPC == 8) &&
          !(PPC == 2 && LANES != 2) && !(PPC == 8 && LANES != 4) &&
          PIX_W >= 14 && PIX_W <= 16)) begin : g_bad_cfg
        $error("raw_pixel_unpacker: illegal LANES/GEAR/PPC/PIX_W combination");
    end

    raw_fmt_e               fmt_q;
    raw_fmt_e               fmt_new;
    logic                   active_q;
    logic                   eop_q;
    logic                   sol_pend_q;
    logic                   phase_q;
    logic                   start;
    logic                   push;
    logic                   can_dec;
    logic                   last_grp;
    logic [CNT_W-1:0]       need;
    logic [CNT_W-1:0]       fill;
    logic [CNT_W-1:0]       pop_cnt;
    logic [CAP*8-1:0]       win;
    logic [DEC_PIX*PIX_W-1:0] dec_pix;
    logic [55:0]            grp_win [NG];

    // Decide what to accept, whether a decode fits, and whether it ends the line.
    always_comb begin
        fmt_new  = fmt_from_dt(in_dt);
        start    = in_valid && in_sop;
        push     = in_valid && (start ? (fmt_new != FMT_NONE) : (active_q && !eop_q));
        need     = CNT_W'(NG * unit_bytes(fmt_q));
        can_dec  = active_q && !phase_q && !start && (fill >= need);
        pop_cnt  = can_dec ? need : '0;
        last_grp = eop_q && ((fill - need) < need);
    end

    raw_residue_buf #(
        .IN_BYTES (IN_BYTES),
        .CAP      (CAP),
        .CNT_W    (CNT_W)
    ) u_resid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .push      (push),
        .push_data (in_data),
        .pop_cnt   (pop_cnt),
        .win       (win),
        .count     (fill)
    );

    // Cut one seven-byte window per decode unit at its format-dependent offset.
    always_comb begin
        int idx;
        for (int g = 0; g < NG; g++) begin
            for (int j = 0; j < 7; j++) begin
                idx = g * unit_bytes(fmt_q) + j;
                grp_win[g][j*8 +: 8] = (idx < CAP) ? win[idx*8 +: 8] : 8'h00;
            end
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_unit
        raw_unit_decode #(.PIX_W(PIX_W)) u_dec (
            .fmt (fmt_q),
            .win (grp_win[g]),
            .pix (dec_pix[g*4*PIX_W +: 4*PIX_W])
        );
    end

    // Track the packet: format, acceptance, end seen and pending line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q      <= FMT_NONE;
            active_q   <= 1'b0;
            eop_q      <= 1'b0;
            sol_pend_q <= 1'b0;
        end else if (start) begin
            fmt_q      <= fmt_new;
            active_q   <= (fmt_new != FMT_NONE);
            eop_q      <= in_eop && (fmt_new != FMT_NONE);
            sol_pend_q <= 1'b1;
        end else begin
            if (push && in_eop) eop_q <= 1'b1;
            if (can_dec) begin
                sol_pend_q <= 1'b0;
                if (last_grp) active_q <= 1'b0;
            end
        end
    end

    if (PPC == 2) begin : g_half
        logic [2*PIX_W-1:0] hold_q;
        logic               last_q;

        // Emit a decoded unit as two beats: lower pair now, upper pair next.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_sol   <= 1'b0;
                out_eol   <= 1'b0;
                out_pix   <= '0;
                hold_q    <= '0;
                last_q    <= 1'b0;
                phase_q   <= 1'b0;
            end else if (start) begin
                out_valid <= 1'b0;
                out_sol   <= 1'b0;
                out_eol   <= 1'b0;
                phase_q   <= 1'b0;
            end else if (can_dec) begin
                out_valid <= 1'b1;
                out_sol   <= sol_pend_q;
                out_eol   <= 1'b0;
                out_pix   <= dec_pix[0 +: 2*PIX_W];
                hold_q    <= dec_pix[2*PIX_W +: 2*PIX_W];
                last_q    <= last_grp;
                phase_q   <= 1'b1;
            end else if (phase_q) begin
                out_valid <= 1'b1;
                out_sol   <= 1'b0;
                out_eol   <= last_q;
                out_pix   <= hold_q;
                phase_q   <= 1'b0;
            end else begin
                out_valid <= 1'b0;
                out_sol   <= 1'b0;
                out_eol   <= 1'b0;
            end
        end
    end else begin : g_full
        // Emit every decoded unit set as one beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_sol   <= 1'b0;
                out_eol   <= 1'b0;
                out_pix   <= '0;
            end else if (can_dec) begin
                out_valid <= 1'b1;
                out_sol   <= sol_pend_q;
                out_eol   <= last_grp;
                out_pix   <= dec_pix[0 +: PPC*PIX_W];
            end else begin
                out_valid <= 1'b0;
                out_sol   <= 1'b0;
                out_eol   <= 1'b0;
            end
        end
        assign phase_q = 1'b0;
    end

    AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid); // R8
    AST_EOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid); // R8
    AST_SOL_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |=> !out_sol); // R8
    AST_UNKNOWN_DT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_NONE) && !phase_q |=> !out_valid); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_sol && !out_eol); // R10

endmodule

// File: tb/tb_raw_pixel_unpacker.sv
// Scoreboard bench: the driver packs random pixels into payload bytes and
// queues the expected beats; the monitor pops and compares each output beat.
module tb_raw_pixel_unpacker;

    localparam int LANES = 2;
    localparam int GEAR  = 8;
    localparam int PPC   = 4;
    localparam int PIX_W = 14;
    localparam int INB   = LANES * GEAR / 8;

    typedef struct packed {
        logic [PPC*PIX_W-1:0] pix;
        logic                 sol;
        logic                 eol;
    } beat_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_sop = 1'b0;
    logic                   in_eop = 1'b0;
    logic [5:0]             in_dt = 6'h00;
    logic [LANES*GEAR-1:0]  in_data = '0;
    logic                   out_valid;
    logic                   out_sol;
    logic                   out_eol;
    logic [PPC*PIX_W-1:0]   out_pix;

    beat_t exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    n_stray  = 0;
    bit    done     = 1'b0;

    always #10 clk = ~clk;

    raw_pixel_unpacker #(.LANES(LANES), .GEAR(GEAR), .PPC(PPC), .PIX_W(PIX_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_dt(in_dt), .in_data(in_data),
        .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol), .out_pix(out_pix)
    );

    // Monitor: compare every output beat against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                n_stray++;
                $display("FAIL R5 stray beat: actual pix=%h sol=%b eol=%b expected none",
                         out_pix, out_sol, out_eol);
            end else begin
                beat_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_pix !== e.pix || out_sol !== e.sol || out_eol !== e.eol) begin
                    n_fails++;
                    $display("FAIL %s R8: actual pix=%h sol=%b eol=%b expected pix=%h sol=%b eol=%b",
                             t, out_pix, out_sol, out_eol, e.pix, e.sol, e.eol);
                end
            end
        end
    end

    // Driver: pack pixels, queue expected beats, send words with optional gaps.
    task automatic send_packet(input logic [5:0] dt, input int depth, input int npix,
                               input int extra, input string tag, input int gap_pct);
        logic [7:0]  bq[$];
        logic [15:0] px[$];
        int nw;
        for (int i = 0; i < npix; i++) px.push_back(16'($urandom) & 16'((1 << depth) - 1));
        if (depth == 10) begin
            for (int g = 0; g < npix; g += 4) begin
                for (int i = 0; i < 4; i++) bq.push_back(px[g+i][9:2]);
                bq.push_back({px[g+3][1:0], px[g+2][1:0], px[g+1][1:0], px[g][1:0]});
            end
        end else if (depth == 12) begin
            for (int g = 0; g < npix; g += 2) begin
                bq.push_back(px[g][11:4]);
                bq.push_back(px[g+1][11:4]);
                bq.push_back({px[g+1][3:0], px[g][3:0]});
            end
        end else if (depth == 14) begin
            for (int g = 0; g < npix; g += 4) begin
                logic [23:0] l;
                for (int i = 0; i < 4; i++) bq.push_back(px[g+i][13:6]);
                l = {px[g+3][5:0], px[g+2][5:0], px[g+1][5:0], px[g][5:0]};
                bq.push_back(l[7:0]);
                bq.push_back(l[15:8]);
                bq.push_back(l[23:16]);
            end
        end
        for (int i = 0; i < extra; i++) bq.push_back(8'($urandom));
        if (depth != 0) begin
            for (int b = 0; b < npix / PPC; b++) begin
                beat_t e;
                for (int k = 0; k < PPC; k++)
                    e.pix[k*PIX_W +: PIX_W] = PIX_W'(px[b*PPC+k]) << (PIX_W - depth);
                e.sol = (b == 0);
                e.eol = (b == npix / PPC - 1);
                exp_q.push_back(e);
                tag_q.push_back(tag);
            end
        end
        nw = bq.size() / INB;
        for (int w = 0; w < nw; w++) begin
            if (w != 0 && $urandom_range(99) < gap_pct) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (w == 0);
            in_eop   = (w == nw - 1);
            in_dt    = dt;
            in_data  = {bq[w*INB+1], bq[w*INB]};
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        int stray_before;
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset.
        n_checks++;
        if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_eol !== 1'b0) begin
            n_fails++;
            $display("FAIL R10: actual valid=%b sol=%b eol=%b expected 0 0 0",
                     out_valid, out_sol, out_eol);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send_packet(6'h2B, 10, 16, 0, "R1 R4", 0);
        send_packet(6'h2C, 12, 16, 0, "R2 R4 R7", 40);
        send_packet(6'h2D, 14, 16, 0, "R3 R4 R7", 40);
        send_packet(6'h2D, 14, 24, 0, "R3 R7", 0);

        // R5: unsupported data type gives no beats.
        stray_before = n_stray;
        send_packet(6'h12, 0, 0, 10, "R5", 0);
        n_checks++;
        if (n_stray != stray_before || exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R5: actual stray=%0d expected %0d", n_stray, stray_before);
        end

        // R9: leftover byte of a short packet must not leak into the next.
        send_packet(6'h2B, 10, 4, 1, "R9", 0);
        send_packet(6'h2C, 12, 8, 0, "R9 R2", 30);

        // R6: depth changes from packet to packet.
        send_packet(6'h2D, 14, 8, 0, "R6 R3", 0);
        send_packet(6'h2B, 10, 8, 0, "R6 R1", 20);
        send_packet(6'h2C, 12, 4, 0, "R6 R2", 0);

        repeat (10) @(negedge clk);
        // R7: every expected beat arrived.
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R7: actual %0d beats missing expected 0", exp_q.size());
        end
        done = 1'b1;
        report();
    end

endmodule